// File: doc/BRIEF.md
# Half-Duplex Transmit Status Tracker

This block sits beside a half-duplex Ethernet transmitter. It gathers the per-frame events the transmitter raises and produces the 17-bit status word that is written back into a transmit descriptor when the frame closes. The events are collisions, carrier faults, deferral, jabber, flush, underflow and the two checksum-offload errors. Collisions need a decision on every occurrence: the tracker either asks the transmitter to retry or aborts the frame. A collision that comes after the collision window, or that reaches the retry limit, ends the frame.

A frame opens with a start pulse and closes with an end pulse or with an abort. While a frame is open, every event pulse sets its bit and the bit stays set. When the frame closes, the word is frozen, and a one-cycle valid pulse marks it as ready to be written back. A byte-time strobe from the transmitter drives the collision-window timer. The window length depends on the selected media interface. The backoff timer and carrier detection are outside the block.

Top module: `tx_stat_tracker`

## Requirements
- R1: After a synchronous reset, `sts_word`, `sts_valid`, `retry_req` and `abort` are all zero.
- R2: A `frm_start` pulse clears every status bit left from the previous frame and opens a new frame.
- R3: In half-duplex mode, a collision inside the window and below the limit pulses `retry_req` for one cycle without `abort`, and it adds one to the collision count reported in `sts_word[6:3]`.
- R4: The 16th collision of a frame sets bit 8 (excessive collision), pulses `abort` without `retry_req` and closes the frame. While bit 8 is set, `sts_word[6:3]` reads zero.
- R5: With `cfg_no_retry` high, the first collision sets bit 8, pulses `abort` and closes the frame.
- R6: A collision after the window sets bit 9 (late collision), pulses `abort` and requests no retry. The window is reached after 64 `byte_tick` strobes when `cfg_gmii` is 0, and after 512 strobes when `cfg_gmii` is 1. The count restarts at frame start and after each retry. Bit 9 reads zero whenever bit 1 (underflow) is set.
- R7: `carrier_sense` low during an open half-duplex frame sets bit 11 (loss of carrier). Bit 11 reads zero if the frame had any collision.
- R8: In full-duplex mode (`cfg_half_duplex` low), collisions, deferral and carrier loss are ignored: they set no bit, leave the count at zero and pulse neither `retry_req` nor `abort`. `ev_defer` sets bit 0 only in half-duplex mode.
- R9: Bit 15 (error summary) is the OR of bits 16, 14, 13, 12, 11, 10, 9, 8, 2 and 1, taken as reported. Bits 0, 7 and 6:3 do not set it.
- R10: `frm_end` or an abort closes the frame, and `sts_valid` pulses for exactly one cycle. Events that arrive while no frame is open leave `sts_word` unchanged.
- R11: Event to bit mapping: `ev_ip_hdr_err`→16, `ev_jabber`→14, `ev_flush`→13, `ev_ip_pay_err`→12, `ev_no_carrier`→10, `ev_vlan`→7, `ev_excess_defer`→2, `ev_underflow`→1, `ev_defer`→0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_duplex | input | 1 | 1 = half-duplex operation |
| cfg_no_retry | input | 1 | 1 = abort on the first collision |
| cfg_gmii | input | 1 | 1 = 512 byte-time window, 0 = 64 byte-time window |
| frm_start | input | 1 | Opens a frame |
| frm_end | input | 1 | Closes a frame normally |
| byte_tick | input | 1 | One byte time has elapsed on the wire |
| carrier_sense | input | 1 | Carrier level from the PHY |
| ev_collision | input | 1 | Collision detected |
| ev_no_carrier | input | 1 | Carrier was never seen |
| ev_defer | input | 1 | Transmitter deferred to carrier |
| ev_excess_defer | input | 1 | Deferral limit exceeded |
| ev_jabber | input | 1 | Jabber timeout |
| ev_flush | input | 1 | Frame flushed |
| ev_underflow | input | 1 | Data arrived late |
| ev_ip_hdr_err | input | 1 | IP header error |
| ev_ip_pay_err | input | 1 | IP payload error |
| ev_vlan | input | 1 | Frame is VLAN tagged |
| sts_word | output | 17 | Descriptor status field |
| sts_valid | output | 1 | One-cycle pulse when the word is frozen |
| retry_req | output | 1 | Retry requested after a collision |
| abort | output | 1 | Frame aborted |

## Verification
Every result is registered exactly once. An event, a collision or `frm_end` sampled at one rising edge shows on `sts_word`, `retry_req`, `abort` and `sts_valid` directly after that edge, and a retry or abort pulse lasts exactly that one cycle. The bench drives inputs on falling edges and samples on the next falling edge, which is the first point where the result is due. For the window boundary it compares 63 and 64 strobes, and it reads each frame's word at the cycle that `sts_valid` marks.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int STS_W = 17;

  typedef struct packed {
    logic ip_hdr;
    logic jabber;
    logic flush;
    logic ip_pay;
    logic lost_carr;
    logic no_carr;
    logic late_coll;
    logic ex_coll;
    logic vlan;
    logic ex_defer;
    logic underflow;
    logic deferred;
  } flags_t;

  // Pack sticky flags into the descriptor status layout with reporting masks.
  function automatic logic [STS_W-1:0] pack_status(flags_t f, logic [3:0] cc, logic any_coll);
    logic [STS_W-1:0] w;
    logic late_rep;
    logic lost_rep;
    w        = '0;
    late_rep = f.late_coll & ~f.underflow;
    lost_rep = f.lost_carr & ~any_coll;
    w[16]    = f.ip_hdr;
    w[14]    = f.jabber;
    w[13]    = f.flush;
    w[12]    = f.ip_pay;
    w[11]    = lost_rep;
    w[10]    = f.no_carr;
    w[9]     = late_rep;
    w[8]     = f.ex_coll;
    w[7]     = f.vlan;
    w[6:3]   = f.ex_coll ? 4'd0 : cc;
    w[2]     = f.ex_defer;
    w[1]     = f.underflow;
    w[0]     = f.deferred;
    w[15]    = f.ip_hdr | f.jabber | f.flush | f.ip_pay | lost_rep | f.no_carr |
               late_rep | f.ex_coll | f.ex_defer | f.underflow;
    return w;
  endfunction
endpackage

// File: rtl/tst_win_timer.sv
module tst_win_timer #(
  parameter int WIN_MII  = 64,
  parameter int WIN_GMII = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic gmii,
  output logic past_window
);
  localparam int CW = $clog2(WIN_GMII + 1);
  localparam logic [CW-1:0] CMAX = CW'(WIN_GMII);
  localparam logic [CW-1:0] CMII = CW'(WIN_MII);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign past_window = gmii ? (cnt >= CMAX) : (cnt >= CMII);
endmodule

// File: rtl/tst_coll_ctrl.sv
module tst_coll_ctrl #(
  parameter int COLL_LIMIT = 16,
  parameter int CC_W       = $clog2(COLL_LIMIT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            active,
  input  logic            coll,
  input  logic            half,
  input  logic            no_retry,
  input  logic            late,
  output logic            hit_late,
  output logic            hit_excess,
  output logic            hit_retry,
  output logic [CC_W-1:0] cnt,
  output logic            retry_q
);
  localparam logic [CC_W-1:0] LAST = CC_W'(COLL_LIMIT - 1);

  logic take;
  assign take       = active & coll & half;
  assign hit_late   = take & late;
  assign hit_excess = take & ~late & (no_retry | (cnt == LAST));
  assign hit_retry  = take & ~late & ~hit_excess;

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (hit_retry && cnt != LAST) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) retry_q <= 1'b0;
    else     retry_q <= hit_retry;
  end
endmodule

// File: rtl/tst_flag_acc.sv
module tst_flag_acc
  import tx_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr,
  input  logic   en,
  input  flags_t ev,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= q | ev;
  end
endmodule

// File: rtl/tx_stat_tracker.sv
module tx_stat_tracker
  import tx_stat_pkg::*;
#(
  parameter int COLL_LIMIT = 16,
  parameter int WIN_MII    = 64,
  parameter int WIN_GMII   = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_half_duplex,
  input  logic             cfg_no_retry,
  input  logic             cfg_gmii,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             byte_tick,
  input  logic             carrier_sense,
  input  logic             ev_collision,
  input  logic             ev_no_carrier,
  input  logic             ev_defer,
  input  logic             ev_excess_defer,
  input  logic             ev_jabber,
  input  logic             ev_flush,
  input  logic             ev_underflow,
  input  logic             ev_ip_hdr_err,
  input  logic             ev_ip_pay_err,
  input  logic             ev_vlan,
  output logic [STS_W-1:0] sts_word,
  output logic             sts_valid,
  output logic             retry_req,
  output logic             abort
);
  localparam int CC_W = $clog2(COLL_LIMIT);

  logic            active_q;
  logic            past_win;
  logic            hit_late, hit_excess, hit_retry;
  logic [CC_W-1:0] cnt;
  logic            abort_now;
  logic [3:0]      cc_rep;
  flags_t          ev_in, flags_q;

  tst_win_timer #(.WIN_MII(WIN_MII), .WIN_GMII(WIN_GMII)) u_win (
    .clk(clk), .rst(rst), .clr(frm_start | hit_retry),
    .tick(byte_tick & active_q), .gmii(cfg_gmii), .past_window(past_win)
  );

  tst_coll_ctrl #(.COLL_LIMIT(COLL_LIMIT), .CC_W(CC_W)) u_coll (
    .clk(clk), .rst(rst), .start(frm_start), .active(active_q),
    .coll(ev_collision), .half(cfg_half_duplex), .no_retry(cfg_no_retry),
    .late(past_win), .hit_late(hit_late), .hit_excess(hit_excess),
    .hit_retry(hit_retry), .cnt(cnt), .retry_q(retry_req)
  );

  always_comb begin
    ev_in           = '0;
    ev_in.ip_hdr    = ev_ip_hdr_err;
    ev_in.jabber    = ev_jabber;
    ev_in.flush     = ev_flush;
    ev_in.ip_pay    = ev_ip_pay_err;
    ev_in.lost_carr = cfg_half_duplex & ~carrier_sense;
    ev_in.no_carr   = ev_no_carrier;
    ev_in.late_coll = hit_late;
    ev_in.ex_coll   = hit_excess;
    ev_in.vlan      = ev_vlan;
    ev_in.ex_defer  = ev_excess_defer;
    ev_in.underflow = ev_underflow;
    ev_in.deferred  = ev_defer & cfg_half_duplex;
  end

  tst_flag_acc u_acc (
    .clk(clk), .rst(rst), .clr(frm_start), .en(active_q), .ev(ev_in), .q(flags_q)
  );

  assign abort_now = hit_late | hit_excess;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      sts_valid <= 1'b0;
      abort     <= 1'b0;
    end else begin
      sts_valid <= active_q & ~frm_start & (frm_end | abort_now);
      abort     <= abort_now;
      if (frm_start)                         active_q <= 1'b1;
      else if (active_q & (frm_end | abort_now)) active_q <= 1'b0;
    end
  end

  assign cc_rep   = (int'(cnt) > 15) ? 4'd15 : 4'(cnt);
  assign sts_word = pack_status(flags_q, cc_rep,
                                (cnt != '0) | flags_q.ex_coll | flags_q.late_coll);
endmodule

// File: rtl/tx_stat_tracker_chk.sv
module tx_stat_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_half_duplex,
  input logic        frm_start,
  input logic [16:0] sts_word,
  input logic        sts_valid,
  input logic        retry_req,
  input logic        abort
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sts_word == '0 && !sts_valid && !retry_req && !abort));

  a_r3_retry_excl_abort: assert property (@(posedge clk) disable iff (rst)
    !(retry_req && abort));

  a_r4_count_hidden: assert property (@(posedge clk) disable iff (rst)
    sts_word[8] |-> sts_word[6:3] == 4'd0);

  a_r6_late_masked: assert property (@(posedge clk) disable iff (rst)
    sts_word[1] |-> !sts_word[9]);

  a_r8_retry_half_only: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> $past(cfg_half_duplex));

  a_r9_summary: assert property (@(posedge clk) disable iff (rst)
    (sts_word[16] | sts_word[14] | sts_word[13] | sts_word[12] | sts_word[11] |
     sts_word[10] | sts_word[9] | sts_word[8] | sts_word[2] | sts_word[1]) == sts_word[15]);

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && !frm_start) |=> $stable(sts_word));

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    sts_valid |=> !sts_valid);
endmodule

bind tx_stat_tracker tx_stat_tracker_chk u_chk (.*);

// File: tb/tx_stat_tracker_bench.sv
`timescale 1ns/1ps
module tx_stat_tracker_bench;
  logic clk = 0;
  logic rst = 1;
  logic cfg_half_duplex = 1, cfg_no_retry = 0, cfg_gmii = 0;
  logic frm_start = 0, frm_end = 0, byte_tick = 0, carrier_sense = 1;
  logic ev_collision = 0, ev_no_carrier = 0, ev_defer = 0, ev_excess_defer = 0;
  logic ev_jabber = 0, ev_flush = 0, ev_underflow = 0, ev_ip_hdr_err = 0;
  logic ev_ip_pay_err = 0, ev_vlan = 0;
  logic [16:0] sts_word;
  logic sts_valid, retry_req, abort;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tx_stat_tracker u_tx_stat_tracker (.*);

  // ev bits: 0 defer,1 underflow,2 excess defer,3 vlan,4 no carrier,
  // 5 ip payload,6 flush,7 jabber,8 ip header,9 carrier drop
  typedef struct packed { logic half; logic [9:0] ev; logic [16:0] exp; } vec_t;
  localparam vec_t VECS [14] = '{
    '{1'b1, 10'h001, 17'h00001}, '{1'b1, 10'h002, 17'h08002},
    '{1'b1, 10'h004, 17'h08004}, '{1'b1, 10'h008, 17'h00080},
    '{1'b1, 10'h010, 17'h08400}, '{1'b1, 10'h020, 17'h09000},
    '{1'b1, 10'h040, 17'h0A000}, '{1'b1, 10'h080, 17'h0C000},
    '{1'b1, 10'h100, 17'h18000}, '{1'b1, 10'h200, 17'h08800},
    '{1'b0, 10'h201, 17'h00000}, '{1'b0, 10'h080, 17'h0C000},
    '{1'b1, 10'h009, 17'h00081}, '{1'b1, 10'h000, 17'h00000}
  };

  task automatic chk(input logic ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic open_frame(input logic half);
    cyc(); cfg_half_duplex = half; frm_start = 1;
    cyc(); frm_start = 0;
  endtask

  task automatic close_frame();
    frm_end = 1; cyc(); frm_end = 0;
  endtask

  task automatic collide();
    ev_collision = 1; cyc(); ev_collision = 0;
  endtask

  task automatic ticks(input int n);
    byte_tick = 1; repeat (n) cyc(); byte_tick = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired R10 actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk(sts_word == 0 && !sts_valid && !retry_req && !abort, "R1 reset", sts_word, 0);

    // R9 R11 R8 R7 vector table
    foreach (VECS[i]) begin
      open_frame(VECS[i].half);
      {ev_ip_hdr_err, ev_jabber, ev_flush, ev_ip_pay_err, ev_no_carrier,
       ev_vlan, ev_excess_defer, ev_underflow, ev_defer} = VECS[i].ev[8:0];
      carrier_sense = ~VECS[i].ev[9];
      cyc();
      {ev_ip_hdr_err, ev_jabber, ev_flush, ev_ip_pay_err, ev_no_carrier,
       ev_vlan, ev_excess_defer, ev_underflow, ev_defer} = '0;
      carrier_sense = 1;
      close_frame();
      chk(sts_valid && sts_word == VECS[i].exp, "R9 R11 table", sts_word, VECS[i].exp);
    end
    cfg_half_duplex = 1;

    // R10 valid lasts one cycle, events after close ignored
    cyc();
    chk(!sts_valid, "R10 valid pulse width", {16'd0, sts_valid}, 0);
    ev_jabber = 1; cyc(); ev_jabber = 0;
    chk(sts_word == 0, "R10 event outside frame", sts_word, 0);

    // R3 three retries
    open_frame(1);
    for (int k = 1; k <= 3; k++) begin
      collide();
      chk(retry_req && !abort && sts_word[6:3] == 4'(k), "R3 retry and count",
          {retry_req, abort, sts_word[14:0]}, 17'(k << 3));
    end
    cyc();
    chk(!retry_req, "R3 retry one cycle", {16'd0, retry_req}, 0);
    // R7 carrier drop after collisions is hidden
    carrier_sense = 0; cyc(); carrier_sense = 1;
    close_frame();
    chk(sts_word == 17'h00018, "R7 lost carrier masked by collision", sts_word, 17'h00018);

    // R2 start clears previous frame
    open_frame(1);
    chk(sts_word == 0, "R2 clear on start", sts_word, 0);

    // R4 sixteen collisions
    for (int k = 1; k <= 15; k++) collide();
    chk(sts_word[6:3] == 4'd15 && retry_req, "R3 count at 15", sts_word, 17'h00078);
    collide();
    chk(abort && !retry_req && sts_valid && sts_word == 17'h08100, "R4 excessive abort",
        sts_word, 17'h08100);
    cyc();
    chk(sts_word == 17'h08100 && !abort, "R4 frozen after abort", sts_word, 17'h08100);

    // R5 no-retry
    cfg_no_retry = 1;
    open_frame(1);
    collide();
    chk(abort && !retry_req && sts_word == 17'h08100, "R5 abort on first", sts_word, 17'h08100);
    cfg_no_retry = 0;

    // R6 boundary: 63 ticks retries, 64 ticks late
    open_frame(1);
    ticks(63);
    collide();
    chk(retry_req && !abort && sts_word == 17'h00008, "R6 inside window", sts_word, 17'h00008);
    ticks(64);
    collide();
    chk(abort && !retry_req && sts_word == 17'h08208, "R6 late collision", sts_word, 17'h08208);

    // R6 larger window when cfg_gmii set
    cfg_gmii = 1;
    open_frame(1);
    ticks(64);
    collide();
    chk(retry_req && sts_word == 17'h00008, "R6 wide window", sts_word, 17'h00008);
    close_frame();
    cfg_gmii = 0;

    // R6 late collision hidden by underflow
    open_frame(1);
    ev_underflow = 1; cyc(); ev_underflow = 0;
    ticks(64);
    collide();
    chk(abort && sts_word == 17'h08002, "R6 late masked by underflow", sts_word, 17'h08002);

    // R8 full duplex collision ignored
    open_frame(0);
    collide();
    chk(!retry_req && !abort && sts_word == 0, "R8 full duplex collision", sts_word, 0);
    close_frame();
    chk(sts_valid && sts_word == 0, "R8 full duplex close", sts_word, 0);

    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule